// File: doc/BRIEF.md
# Shared Time Base and Watchdog Timer

This block derives a slow periodic time base from a system tick and builds a watchdog on top of it. One 8-stage counter serves both functions. It advances once per base tick. A tick at the slow source rate is used as a base tick directly. When the fast source is selected, a 3-stage prescaler first divides the tick by eight. A 3-bit rate option `n` picks a tap on the counter, so the time base fires once every 2^n base ticks. A 2-stage counter counts those time-base events, and on its fourth event it sets a sticky time-out flag.

Single-cycle commands control the block. They start or stop the shared counter, clear either counter, set the rate, and choose what drives the active-low interrupt output. The time base and the watchdog share one counter, so stopping the watchdog also stops the time base. A low system enable freezes all counting without losing state.

Top module: `tbase_wdog`

## Requirements
- R1: After reset the counters are stopped and cleared, the rate is 0, the flag is clear, `tb_tick` is low and `irq_n` is high because the interrupt source is off. Ticks have no effect until a start command.
- R2: When `src_fast`=0, every tick accepted while running advances the shared counter by one. The first event then comes on the 2^n-th tick after a clear.
- R3: When `src_fast`=1, only every eighth accepted tick advances the shared counter, counted from the last prescaler clear.
- R4: Command opcode 5 loads `cmd_arg` as the rate `n`. `tb_tick` then pulses for one cycle once every 2^n base ticks.
- R5: The watchdog flag is set by the fourth time-base event after a watchdog clear, and it stays set until cleared.
- R6: Opcode 3 clears the 2-stage watchdog counter and the flag.
- R7: Opcode 4 clears the shared counter and the prescaler.
- R8: Opcode 1 stops the shared counter, which halts both the time base and the watchdog. The count and the flag are held.
- R9: Opcode 2 starts counting and routes the flag to the interrupt, so `irq_n` is low exactly while the flag is set.
- R10: Opcode 6 routes the time base to the interrupt. `irq_n` goes low in the cycle after an event and returns high after the next base tick that carries no event.
- R11: Opcode 7 disconnects the interrupt, so `irq_n` stays high whatever the flag holds.
- R12: While `sys_en` is low, ticks are ignored, and all counters and the flag hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sys_en | input | 1 | System clock enable; low freezes all counting |
| src_fast | input | 1 | 1 selects the fast source and turns on the divide-by-eight prescaler |
| tick_in | input | 1 | One-cycle source tick |
| cmd_valid | input | 1 | Command strobe |
| cmd_op | input | 3 | Opcode: 0 none, 1 stop, 2 start with flag-to-interrupt routing, 3 watchdog clear, 4 time-base clear, 5 set rate, 6 time base to interrupt, 7 interrupt off |
| cmd_arg | input | 3 | Rate value for opcode 5 |
| tb_tick | output | 1 | One-cycle pulse per time-base event |
| wdt_flag | output | 1 | Sticky watchdog time-out flag |
| irq_n | output | 1 | Active-low interrupt |

## Verification
The assertions check on every cycle that the flag is sticky, that the flag only rises right after an event, and that the counter holds whenever no base tick arrives. They also check that the prescaler never produces back-to-back base ticks and that the stop, routing and interrupt-off commands take effect. Only the bench scenarios can show the actual event rates for each tap under both source speeds, the exact four-event time-out, and that a stop or a frozen enable resumes from the held count. They also show the clear commands restarting the counts at the right phase.

// File: rtl/tbw_pkg.sv
package tbw_pkg;
    localparam int OP_BITS   = 3;
    localparam int RATE_BITS = 3;

    typedef enum logic [OP_BITS-1:0] {
        OP_NOP     = 3'd0,
        OP_WDT_DIS = 3'd1,
        OP_WDT_EN  = 3'd2,
        OP_WDT_CLR = 3'd3,
        OP_TB_CLR  = 3'd4,
        OP_RATE    = 3'd5,
        OP_IRQ_TB  = 3'd6,
        OP_IRQ_OFF = 3'd7
    } op_e;

    typedef enum logic [1:0] {
        IRQ_SRC_OFF = 2'd0,
        IRQ_SRC_TB  = 2'd1,
        IRQ_SRC_WDT = 2'd2
    } irq_src_e;
endpackage

// File: rtl/tbw_prescaler.sv
module tbw_prescaler #(
    parameter int PRE_BITS = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_en,
    input  logic fast,
    input  logic clr,
    output logic base_tick
);
    typedef struct packed {
        logic [PRE_BITS-1:0] cnt;
    } pre_s;

    pre_s s_d, s_q;

    always_comb begin
        s_d       = s_q;
        base_tick = 1'b0;
        if (clr) begin
            s_d.cnt = '0;
        end else if (tick_en) begin
            if (fast) begin
                s_d.cnt   = s_q.cnt + 1'b1;
                base_tick = (s_q.cnt == {PRE_BITS{1'b1}});
            end else begin
                base_tick = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    // R3: a divided base tick can never be followed at once by another
    p_pre_gap_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (fast && base_tick) |=> (!base_tick || !fast));
endmodule

// File: rtl/tbw_base_counter.sv
module tbw_base_counter #(
    parameter int CNT_BITS  = 8,
    parameter int RATE_BITS = 3
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 base_tick,
    input  logic                 clr,
    input  logic [RATE_BITS-1:0] rate,
    output logic                 evt
);
    localparam logic [CNT_BITS-1:0] ONE = {{(CNT_BITS-1){1'b0}}, 1'b1};

    typedef struct packed {
        logic [CNT_BITS-1:0] cnt;
    } cnt_s;

    cnt_s s_d, s_q;
    logic [CNT_BITS-1:0] mask;

    always_comb begin
        mask = (ONE << rate) - ONE;
        s_d  = s_q;
        evt  = 1'b0;
        if (clr) begin
            s_d.cnt = '0;
        end else if (base_tick) begin
            s_d.cnt = s_q.cnt + ONE;
            evt     = ((s_q.cnt & mask) == mask);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    // R8 / R12: without a base tick the shared count never moves
    p_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (!base_tick && !clr) |=> $stable(s_q.cnt));

    // R7: a clear leaves the count at zero
    p_clr_r7: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (s_q.cnt == '0));
endmodule

// File: rtl/tbw_watchdog.sv
module tbw_watchdog #(
    parameter int WDT_BITS = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic evt,
    input  logic clr,
    output logic flag
);
    typedef struct packed {
        logic [WDT_BITS-1:0] cnt;
        logic                flag;
    } wdt_s;

    wdt_s s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (clr) begin
            s_d = '0;
        end else if (evt) begin
            s_d.cnt = s_q.cnt + 1'b1;
            if (s_q.cnt == {WDT_BITS{1'b1}}) s_d.flag = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign flag = s_q.flag;

    // R5: the time-out flag is sticky
    p_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.flag && !clr) |=> s_q.flag);

    // R5: the flag rises only right after a time-base event
    p_cause_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(s_q.flag) |-> $past(evt));

    // R6: a watchdog clear empties the counter and the flag
    p_clr_r6: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (!s_q.flag && s_q.cnt == '0));
endmodule

// File: rtl/tbase_wdog.sv
module tbase_wdog
    import tbw_pkg::*;
#(
    parameter int PRE_BITS = 3,
    parameter int CNT_BITS = 8,
    parameter int WDT_BITS = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 sys_en,
    input  logic                 src_fast,
    input  logic                 tick_in,
    input  logic                 cmd_valid,
    input  logic [OP_BITS-1:0]   cmd_op,
    input  logic [RATE_BITS-1:0] cmd_arg,
    output logic                 tb_tick,
    output logic                 wdt_flag,
    output logic                 irq_n
);
    typedef struct packed {
        logic                 run;
        irq_src_e             sel;
        logic [RATE_BITS-1:0] rate;
        logic                 pulse;
        logic                 tbt;
    } top_s;

    top_s s_d, s_q;

    logic tick_en, base_tick, evt, tb_clr, wdt_clr, flag;

    assign tick_en = tick_in && sys_en && s_q.run;
    assign tb_clr  = cmd_valid && (cmd_op == OP_TB_CLR);
    assign wdt_clr = cmd_valid && (cmd_op == OP_WDT_CLR);

    tbw_prescaler #(.PRE_BITS(PRE_BITS)) u_pre (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .fast(src_fast),
        .clr(tb_clr), .base_tick(base_tick)
    );

    tbw_base_counter #(.CNT_BITS(CNT_BITS), .RATE_BITS(RATE_BITS)) u_cnt (
        .clk(clk), .rst_n(rst_n), .base_tick(base_tick), .clr(tb_clr),
        .rate(s_q.rate), .evt(evt)
    );

    tbw_watchdog #(.WDT_BITS(WDT_BITS)) u_wdt (
        .clk(clk), .rst_n(rst_n), .evt(evt), .clr(wdt_clr), .flag(flag)
    );

    always_comb begin
        s_d     = s_q;
        s_d.tbt = evt;
        if (evt)            s_d.pulse = 1'b1;
        else if (base_tick) s_d.pulse = 1'b0;
        if (cmd_valid) begin
            case (op_e'(cmd_op))
                OP_WDT_DIS: s_d.run = 1'b0;
                OP_WDT_EN: begin
                    s_d.run = 1'b1;
                    s_d.sel = IRQ_SRC_WDT;
                end
                OP_RATE:    s_d.rate = cmd_arg;
                OP_IRQ_TB:  s_d.sel = IRQ_SRC_TB;
                OP_IRQ_OFF: s_d.sel = IRQ_SRC_OFF;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{run: 1'b0, sel: IRQ_SRC_OFF, rate: '0, pulse: 1'b0, tbt: 1'b0};
        end else begin
            s_q <= s_d;
        end
    end

    assign tb_tick  = s_q.tbt;
    assign wdt_flag = flag;
    always_comb begin
        case (s_q.sel)
            IRQ_SRC_TB:  irq_n = !s_q.pulse;
            IRQ_SRC_WDT: irq_n = !flag;
            default:     irq_n = 1'b1;
        endcase
    end

    // R8: two cycles after a stop command no event is reported
    p_stop_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_op == OP_WDT_DIS) |=> ##1 !tb_tick);

    // R9: after a start the flag drives the interrupt
    p_route_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_op == OP_WDT_EN) |=> (!wdt_flag || !irq_n));

    // R10: a time-base event is seen on the interrupt when it is routed there
    p_tbirq_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.sel == IRQ_SRC_TB && tb_tick) |-> !irq_n);

    // R11: interrupt off keeps the line high
    p_off_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_op == OP_IRQ_OFF) |=> irq_n);

    // R12: a low system enable suppresses events
    p_frozen_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !sys_en |=> !tb_tick);
endmodule

// File: tb/tbase_wdog_bench.sv
module tbase_wdog_bench;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sys_en = 1'b1;
    logic src_fast = 1'b0;
    logic tick_in = 1'b0;
    logic cmd_valid = 1'b0;
    logic [2:0] cmd_op = 3'd0;
    logic [2:0] cmd_arg = 3'd0;
    logic tb_tick, wdt_flag, irq_n;

    int n_checks = 0;
    int n_fail = 0;
    int ev = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    tbase_wdog u_tbase_wdog (
        .clk(clk), .rst_n(rst_n), .sys_en(sys_en), .src_fast(src_fast),
        .tick_in(tick_in), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_arg(cmd_arg), .tb_tick(tb_tick), .wdt_flag(wdt_flag), .irq_n(irq_n)
    );

    // vector: fast, rate, tick count
    localparam int NV = 7;
    localparam int VEC [NV][3] = '{
        '{0, 0, 5}, '{0, 2, 12}, '{0, 3, 33}, '{1, 0, 20},
        '{1, 1, 64}, '{0, 7, 300}, '{1, 2, 100}
    };

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic cmd(input logic [2:0] op, input logic [2:0] arg);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = op; cmd_arg = arg;
        @(negedge clk);
        cmd_valid = 1'b0; cmd_op = 3'd0; cmd_arg = 3'd0;
    endtask

    task automatic tick();
        @(negedge clk);
        tick_in = 1'b1;
        @(negedge clk);
        tick_in = 1'b0;
        if (tb_tick) ev++;
    endtask

    task automatic ticks(input int k);
        for (int i = 0; i < k; i++) tick();
    endtask

    task automatic restart(input logic [2:0] rate);
        cmd(3'd4, 3'd0);
        cmd(3'd3, 3'd0);
        cmd(3'd5, rate);
        cmd(3'd2, 3'd0);
        ev = 0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check(irq_n == 1'b1, "R1 irq_n", irq_n, 1);
        check(wdt_flag == 1'b0, "R1 flag", wdt_flag, 0);
        check(tb_tick == 1'b0, "R1 tb_tick", tb_tick, 0);
        ev = 0;
        ticks(6);
        check(ev == 0, "R1 stopped after reset", ev, 0);

        // R2 R3 R4 R5 vector table
        for (int v = 0; v < NV; v++) begin
            int base, exp_ev;
            src_fast = VEC[v][0][0];
            restart(VEC[v][1][2:0]);
            ticks(VEC[v][2]);
            base   = VEC[v][0] != 0 ? VEC[v][2] / 8 : VEC[v][2];
            exp_ev = base / (1 << VEC[v][1]);
            check(ev == exp_ev, VEC[v][0] != 0 ? "R3 R4 events" : "R2 R4 events", ev, exp_ev);
            check(wdt_flag == (exp_ev >= 4), "R5 flag", wdt_flag, int'(exp_ev >= 4));
            check(irq_n == !(exp_ev >= 4), "R9 irq follows flag", irq_n, int'(exp_ev < 4));
        end
        src_fast = 1'b0;

        // R10: time base routed to irq
        restart(3'd1);
        cmd(3'd6, 3'd0);
        tick();
        check(irq_n == 1'b1, "R10 no event yet", irq_n, 1);
        tick();
        check(irq_n == 1'b0, "R10 low after event", irq_n, 0);
        @(negedge clk);
        check(irq_n == 1'b0, "R10 held low", irq_n, 0);
        tick();
        check(irq_n == 1'b1, "R10 high after next tick", irq_n, 1);

        // R6: watchdog clear
        restart(3'd0);
        ticks(4);
        check(wdt_flag == 1'b1, "R5 flag set", wdt_flag, 1);
        cmd(3'd3, 3'd0);
        check(wdt_flag == 1'b0, "R6 flag cleared", wdt_flag, 0);
        check(irq_n == 1'b1, "R9 irq released", irq_n, 1);
        ticks(3);
        check(wdt_flag == 1'b0, "R6 count cleared", wdt_flag, 0);
        tick();
        check(wdt_flag == 1'b1, "R6 fourth event", wdt_flag, 1);
        check(irq_n == 1'b0, "R9 irq low with flag", irq_n, 0);

        // R11: interrupt off
        cmd(3'd7, 3'd0);
        check(irq_n == 1'b1, "R11 irq off", irq_n, 1);
        check(wdt_flag == 1'b1, "R11 flag kept", wdt_flag, 1);

        // R8: stop holds count
        restart(3'd1);
        tick();
        cmd(3'd1, 3'd0);
        ev = 0;
        ticks(5);
        check(ev == 0, "R8 stopped", ev, 0);
        cmd(3'd2, 3'd0);
        tick();
        check(ev == 1, "R8 count held", ev, 1);

        // R12: system enable low freezes
        restart(3'd1);
        tick();
        sys_en = 1'b0;
        ticks(5);
        check(ev == 0, "R12 frozen", ev, 0);
        sys_en = 1'b1;
        tick();
        check(ev == 1, "R12 resumes", ev, 1);

        // R7: time-base clear
        restart(3'd1);
        tick();
        cmd(3'd4, 3'd0);
        tick();
        check(ev == 0, "R7 counter cleared", ev, 0);
        tick();
        check(ev == 1, "R7 event after clear", ev, 1);
        src_fast = 1'b1;
        restart(3'd0);
        ticks(5);
        cmd(3'd4, 3'd0);
        ticks(7);
        check(ev == 0, "R7 prescaler cleared", ev, 0);
        tick();
        check(ev == 1, "R7 eighth tick", ev, 1);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end
endmodule